// File: doc/BRIEF.md
# Atomic Swap and Compare-Swap Memory Unit

This block is a small byte-addressed memory with a request/response front end that carries out atomic read-modify-write operations. Each request names an operation, an address, an access size of 1, 2, 4 or 8 bytes, write data, a conditional flag and a compare value. A read-modify-write fetches the old contents and returns them. It then stores the new data either always (swap) or only when the old contents equal the compare value (compare-and-swap). Plain reads and writes are also served. Invalidate requests are acknowledged without any memory access.

The unit handles one request at a time. The read and the write of an atomic operation run in back-to-back cycles, and the request port stays closed from acceptance until the response has been taken. No other request can fall between the fetch and the store. Both edges of the block use valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. A response stays on the port, with all of its fields stable, until `rsp_ready` is seen high while `rsp_valid` is high. The block starts no new request while a response is still waiting.

Top module: `rmw_mem_unit`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, and every memory byte reads as zero.
- R2: Only one request is in flight at a time. `req_ready` stays low from acceptance until the response has been taken. While `rsp_valid` is high and `rsp_ready` is low, the response fields hold steady.
- R3: Operation code 0 is a read. The access size code selects 1, 2, 4 or 8 bytes (code 0, 1, 2 or 3). The read returns the bytes at addr..addr+size-1, little-endian, in the low bytes of `rsp_data`, with the upper bits zero and `rsp_ok` set.
- R4: Operation code 1 is a write. It stores the low size bytes of `req_wdata` at the address and leaves every other byte unchanged. The response has `rsp_stored` set and `rsp_data` zero.
- R5: Operation code 3 with `req_cond` low is a swap. It returns the old contents of the addressed bytes and always stores the new data, with `rsp_stored` set. 1-byte and 2-byte read-modify-writes are always swaps.
- R6: Operation code 3 with `req_cond` high and size 4 or 8 bytes is a compare-and-swap. It returns the old contents. It stores the new data only when the old contents equal the low size bytes of `req_cmp`. `rsp_stored` tells which case occurred.
- R7: A conditional read-modify-write of 1 or 2 bytes is an error and leaves memory unchanged. `req_cond` has no effect on any other operation.
- R8: Operation code 2 is an invalidate. It answers with `rsp_ok` set, `rsp_stored` clear and `rsp_data` zero, and it leaves memory unchanged.
- R9: Operation codes 4 to 7 are errors and leave memory unchanged.
- R10: An address that is not a multiple of the access size is an error and leaves memory unchanged.
- R11: An error response has `rsp_err` set, `rsp_ok` clear, `rsp_stored` clear and `rsp_data` zero. Every other response has `rsp_ok` set and `rsp_err` clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_op | input | 3 | Operation: 0 read, 1 write, 2 invalidate, 3 read-modify-write |
| req_size | input | 2 | Access size code: bytes = 2**code |
| req_cond | input | 1 | Read-modify-write is conditional |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | New data, low-justified |
| req_cmp | input | DW | Compare value, low-justified |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_data | output | DW | Old or read data, low-justified |
| rsp_ok | output | 1 | Request completed successfully |
| rsp_err | output | 1 | Request rejected |
| rsp_stored | output | 1 | Memory was written by this request |

## Verification
The bench builds the unit with its default parameters: a 7-bit address and a 64-bit word. That gives sixteen words, so both the first and the last word can be reached, and every size code, including full 8-byte compares, fits in one word. A small array keeps the check cheap. Sub-word lanes at high offsets, compares that differ only in upper bytes, and a byte-granular merge in the top half of a word all get exercised against a state the bench tracks by hand.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  localparam logic [2:0] OP_READ  = 3'd0;
  localparam logic [2:0] OP_WRITE = 3'd1;
  localparam logic [2:0] OP_INVAL = 3'd2;
  localparam logic [2:0] OP_RMW   = 3'd3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EXEC  = 2'd2,
    ST_RESP  = 2'd3
  } rmw_state_e;
endpackage

// File: rtl/rmw_decode.sv
module rmw_decode #(
  parameter int DW = 64,
  localparam int BYTES = DW / 8,
  localparam int OFFW = $clog2(BYTES)
) (
  input  logic [2:0]       op,
  input  logic [1:0]       size,
  input  logic             cond,
  input  logic [OFFW-1:0]  offs,
  output logic             is_read,
  output logic             is_write,
  output logic             is_rmw,
  output logic             bad,
  output logic             need_fetch,
  output logic [BYTES-1:0] lane_en,
  output logic [DW-1:0]    val_mask
);
  import rmw_pkg::*;

  logic [OFFW:0] nbytes;
  logic          bad_op;
  logic          misalign;
  logic          bad_cond;

  always_comb begin
    nbytes   = (OFFW+1)'(1) << size;
    is_read  = (op == OP_READ);
    is_write = (op == OP_WRITE);
    is_rmw   = (op == OP_RMW);
    bad_op   = (op > OP_RMW);
    misalign = ((offs & OFFW'(nbytes - (OFFW+1)'(1))) != '0);
    bad_cond = is_rmw && cond && (size < 2'd2);
    bad      = bad_op || misalign || bad_cond;
    need_fetch = !bad && (is_read || is_rmw);
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign lane_en[b] = ((OFFW+1)'(b) >= {1'b0, offs}) &&
                        ((OFFW+1)'(b) < ({1'b0, offs} + nbytes));
    assign val_mask[b*8 +: 8] = {8{(OFFW+1)'(b) < nbytes}};
  end
endmodule

// File: rtl/rmw_store.sv
module rmw_store #(
  parameter int DW = 64,
  parameter int WORDS = 16,
  localparam int BYTES = DW / 8,
  localparam int IW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IW-1:0]    rd_idx,
  output logic [DW-1:0]    rd_word,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [BYTES-1:0] wr_lane,
  input  logic [DW-1:0]    wr_word
);
  logic [DW-1:0] cells [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_word <= '0;
    end else if (rd_en) begin
      rd_word <= cells[rd_idx];
    end
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int w = 0; w < WORDS; w++) cells[w][b*8 +: 8] <= '0;
      end else if (wr_en && wr_lane[b]) begin
        cells[wr_idx][b*8 +: 8] <= wr_word[b*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/rmw_mem_unit.sv
module rmw_mem_unit #(
  parameter int AW = 7,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [1:0]    req_size,
  input  logic          req_cond,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] req_cmp,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_ok,
  output logic          rsp_err,
  output logic          rsp_stored
);
  import rmw_pkg::*;

  localparam int BYTES = DW / 8;
  localparam int OFFW  = $clog2(BYTES);
  localparam int IW    = AW - OFFW;
  localparam int WORDS = 1 << IW;

  rmw_state_e    state;
  logic [2:0]    q_op;
  logic [1:0]    q_size;
  logic          q_cond;
  logic [AW-1:0] q_addr;
  logic [DW-1:0] q_wdata;
  logic [DW-1:0] q_cmp;

  logic             is_read, is_write, is_rmw, bad, need_fetch;
  logic [BYTES-1:0] lane_en;
  logic [DW-1:0]    val_mask;
  logic [DW-1:0]    rd_word;
  logic [DW-1:0]    old_val;
  logic [DW-1:0]    wr_word;
  logic             match;
  logic             do_store;
  logic [OFFW-1:0]  offs;
  logic [IW-1:0]    widx;

  assign offs = q_addr[OFFW-1:0];
  assign widx = q_addr[AW-1:OFFW];

  rmw_decode #(.DW(DW)) u_dec (
    .op(q_op), .size(q_size), .cond(q_cond), .offs(offs),
    .is_read(is_read), .is_write(is_write), .is_rmw(is_rmw),
    .bad(bad), .need_fetch(need_fetch),
    .lane_en(lane_en), .val_mask(val_mask)
  );

  always_comb begin
    old_val  = (rd_word >> {offs, 3'b000}) & val_mask;
    wr_word  = (q_wdata & val_mask) << {offs, 3'b000};
    match    = ((old_val ^ q_cmp) & val_mask) == '0;
    do_store = !bad && (is_write || (is_rmw && (!q_cond || match)));
  end

  rmw_store #(.DW(DW), .WORDS(WORDS)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .rd_en(state == ST_FETCH && need_fetch), .rd_idx(widx), .rd_word(rd_word),
    .wr_en(state == ST_EXEC && do_store), .wr_idx(widx),
    .wr_lane(lane_en), .wr_word(wr_word)
  );

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_RESP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      q_op       <= '0;
      q_size     <= '0;
      q_cond     <= 1'b0;
      q_addr     <= '0;
      q_wdata    <= '0;
      q_cmp      <= '0;
      rsp_data   <= '0;
      rsp_ok     <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_stored <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          q_op    <= req_op;
          q_size  <= req_size;
          q_cond  <= req_cond;
          q_addr  <= req_addr;
          q_wdata <= req_wdata;
          q_cmp   <= req_cmp;
          state   <= ST_FETCH;
        end
        ST_FETCH: state <= ST_EXEC;
        ST_EXEC: begin
          rsp_data   <= (!bad && (is_read || is_rmw)) ? old_val : '0;
          rsp_ok     <= !bad;
          rsp_err    <= bad;
          rsp_stored <= do_store;
          state      <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rmw_mem_unit_chk.sv
module rmw_mem_unit_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [2:0]    req_op,
  input logic [1:0]    req_size,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_data,
  input logic          rsp_ok,
  input logic          rsp_err,
  input logic          rsp_stored
);
  logic [2:0] c_op;
  logic [1:0] c_size;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_op   <= '0;
      c_size <= '0;
    end else if (req_valid && req_ready) begin
      c_op   <= req_op;
      c_size <= req_size;
    end
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) &&
      $stable(rsp_ok) && $stable(rsp_err) && $stable(rsp_stored));

  a_r2_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  a_r11_err_shape: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> !rsp_ok && !rsp_stored && rsp_data == '0);

  a_r11_ok_xor: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_ok != rsp_err);

  a_r3_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && c_size == 2'd0 |-> rsp_data[DW-1:8] == '0);

  a_r8_inval: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && c_op == 3'd2 |-> rsp_ok && !rsp_stored && rsp_data == '0);

  a_r9_badop: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && c_op > 3'd3 |-> rsp_err);
endmodule

bind rmw_mem_unit rmw_mem_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_size(req_size), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_ok(rsp_ok),
  .rsp_err(rsp_err), .rsp_stored(rsp_stored)
);

// File: tb/rmw_mem_unit_bench.sv
`timescale 1ns/1ps
module rmw_mem_unit_bench;
  localparam int AW = 7;
  localparam int DW = 64;

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  sz;
    logic        cond;
    logic [6:0]  addr;
    logic [63:0] wd;
    logic [63:0] cmp;
    logic [63:0] exp;
    logic        ok;
    logic        st;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 2'd3, 1'b0, 7'h00, 64'h1122334455667788, 64'h0, 64'h0, 1'b1, 1'b1, 4'd4},  // R4
    '{3'd0, 2'd3, 1'b0, 7'h00, 64'h0, 64'h0, 64'h1122334455667788, 1'b1, 1'b0, 4'd3},  // R3
    '{3'd0, 2'd0, 1'b0, 7'h03, 64'h0, 64'h0, 64'h55, 1'b1, 1'b0, 4'd3},                // R3
    '{3'd0, 2'd1, 1'b0, 7'h06, 64'h0, 64'h0, 64'h1122, 1'b1, 1'b0, 4'd3},              // R3
    '{3'd1, 2'd1, 1'b0, 7'h02, 64'hFFFFABCD, 64'h0, 64'h0, 1'b1, 1'b1, 4'd4},          // R4
    '{3'd0, 2'd2, 1'b0, 7'h00, 64'h0, 64'h0, 64'hABCD7788, 1'b1, 1'b0, 4'd4},          // R4
    '{3'd3, 2'd0, 1'b0, 7'h07, 64'h99, 64'h0, 64'h11, 1'b1, 1'b1, 4'd5},               // R5
    '{3'd3, 2'd2, 1'b1, 7'h04, 64'hDEADBEEF, 64'h99223344, 64'h99223344, 1'b1, 1'b1, 4'd6}, // R6
    '{3'd3, 2'd2, 1'b1, 7'h04, 64'h0, 64'h12345678, 64'hDEADBEEF, 1'b1, 1'b0, 4'd6},   // R6
    '{3'd0, 2'd3, 1'b0, 7'h00, 64'h0, 64'h0, 64'hDEADBEEFABCD7788, 1'b1, 1'b0, 4'd6},  // R6
    '{3'd3, 2'd3, 1'b1, 7'h08, 64'hCAFE, 64'h0, 64'h0, 1'b1, 1'b1, 4'd6},              // R6
    '{3'd3, 2'd1, 1'b1, 7'h08, 64'h1, 64'h0, 64'h0, 1'b0, 1'b0, 4'd7},                 // R7
    '{3'd0, 2'd3, 1'b0, 7'h08, 64'h0, 64'h0, 64'hCAFE, 1'b1, 1'b0, 4'd7},              // R7
    '{3'd2, 2'd3, 1'b0, 7'h08, 64'hFFFF, 64'h0, 64'h0, 1'b1, 1'b0, 4'd8},              // R8
    '{3'd0, 2'd3, 1'b0, 7'h08, 64'h0, 64'h0, 64'hCAFE, 1'b1, 1'b0, 4'd8},              // R8
    '{3'd5, 2'd3, 1'b0, 7'h08, 64'h1234, 64'h0, 64'h0, 1'b0, 1'b0, 4'd9},              // R9
    '{3'd1, 2'd2, 1'b0, 7'h0A, 64'h77777777, 64'h0, 64'h0, 1'b0, 1'b0, 4'd10},         // R10
    '{3'd0, 2'd3, 1'b0, 7'h08, 64'h0, 64'h0, 64'hCAFE, 1'b1, 1'b0, 4'd10},             // R10
    '{3'd3, 2'd3, 1'b0, 7'h78, 64'h0102030405060708, 64'h0, 64'h0, 1'b1, 1'b1, 4'd5},  // R5
    '{3'd0, 2'd0, 1'b0, 7'h7F, 64'h0, 64'h0, 64'h01, 1'b1, 1'b0, 4'd5},                // R5
    '{3'd1, 2'd3, 1'b1, 7'h10, 64'h55, 64'h0, 64'h0, 1'b1, 1'b1, 4'd7},                // R7
    '{3'd0, 2'd2, 1'b0, 7'h10, 64'h0, 64'h0, 64'h55, 1'b1, 1'b0, 4'd7},                // R7
    '{3'd3, 2'd1, 1'b0, 7'h0E, 64'hBEEF, 64'h0, 64'h0, 1'b1, 1'b1, 4'd5},              // R5
    '{3'd0, 2'd3, 1'b0, 7'h08, 64'h0, 64'h0, 64'hBEEF00000000CAFE, 1'b1, 1'b0, 4'd4},  // R4
    '{3'd3, 2'd2, 1'b1, 7'h12, 64'h0, 64'h0, 64'h0, 1'b0, 1'b0, 4'd10}                 // R10
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [2:0]    req_op = '0;
  logic [1:0]    req_size = '0;
  logic          req_cond = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] req_cmp = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [DW-1:0] rsp_data;
  logic          rsp_ok;
  logic          rsp_err;
  logic          rsp_stored;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  rmw_mem_unit #(.AW(AW), .DW(DW)) u_rmw_mem_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_size(req_size), .req_cond(req_cond),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_cmp(req_cmp),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_ok(rsp_ok), .rsp_err(rsp_err), .rsp_stored(rsp_stored)
  );

  task automatic check(input logic good, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [1:0] sz, input logic cond,
                       input logic [6:0] addr, input logic [63:0] wd,
                       input logic [63:0] cmp);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_size = sz; req_cond = cond;
    req_addr = addr; req_wdata = wd; req_cmp = cmp;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic collect(output logic [63:0] d, output logic ok,
                         output logic er, output logic st);
    while (!rsp_valid) @(negedge clk);
    d = rsp_data; ok = rsp_ok; er = rsp_err; st = rsp_stored;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic ok, er, st;

    do_reset();
    check(req_ready === 1'b1, "R1 ready after reset", {63'd0, req_ready}, 64'd1);
    check(rsp_valid === 1'b0, "R1 no response after reset", {63'd0, rsp_valid}, 64'd0);
    issue(3'd0, 2'd3, 1'b0, 7'h30, 64'h0, 64'h0);
    collect(d, ok, er, st);
    check(d === 64'h0 && ok, "R1 memory zero after reset", d, 64'h0);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].op, VECS[i].sz, VECS[i].cond, VECS[i].addr, VECS[i].wd, VECS[i].cmp);
      collect(d, ok, er, st);
      n_chk++;
      if (d !== VECS[i].exp || ok !== VECS[i].ok || er !== !VECS[i].ok ||
          st !== VECS[i].st) begin
        n_fail++;
        $display("FAIL R%0d vec %0d actual=%h ok%0b err%0b st%0b expected=%h ok%0b st%0b",
                 VECS[i].tag, i, d, ok, er, st, VECS[i].exp, VECS[i].ok, VECS[i].st);
      end
    end

    // R2: back-pressure holds the response and keeps the request port closed
    rsp_ready = 1'b0;
    issue(3'd0, 2'd3, 1'b0, 7'h00, 64'h0, 64'h0);
    while (!rsp_valid) @(negedge clk);
    d = rsp_data;
    repeat (5) @(negedge clk);
    check(rsp_valid === 1'b1, "R2 response held", {63'd0, rsp_valid}, 64'd1);
    check(rsp_data === d, "R2 data stable", rsp_data, d);
    check(req_ready === 1'b0, "R2 port closed", {63'd0, req_ready}, 64'd0);
    check(d === 64'hDEADBEEFABCD7788, "R2 held data value", d, 64'hDEADBEEFABCD7788);
    rsp_ready = 1'b1;
    @(negedge clk);
    check(rsp_valid === 1'b0 && req_ready === 1'b1, "R2 released",
          {62'd0, rsp_valid, req_ready}, 64'd1);

    // R7: conditional 1-byte swap rejected, byte untouched
    issue(3'd3, 2'd0, 1'b1, 7'h7F, 64'hEE, 64'h01);
    collect(d, ok, er, st);
    check(er === 1'b1 && st === 1'b0, "R7 cond byte error", {62'd0, er, st}, 64'd2);
    issue(3'd0, 2'd0, 1'b0, 7'h7F, 64'h0, 64'h0);
    collect(d, ok, er, st);
    check(d === 64'h01, "R7 byte unchanged", d, 64'h01);

    // R6: compare differing only in top byte fails
    issue(3'd3, 2'd3, 1'b1, 7'h78, 64'h0, 64'hFF02030405060708);
    collect(d, ok, er, st);
    check(d === 64'h0102030405060708 && st === 1'b0, "R6 upper byte mismatch",
          d, 64'h0102030405060708);

    // R1: reset mid-run clears memory
    do_reset();
    issue(3'd0, 2'd3, 1'b0, 7'h00, 64'h0, 64'h0);
    collect(d, ok, er, st);
    check(d === 64'h0, "R1 cleared by reset", d, 64'h0);

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule